// File: doc/BRIEF.md
# Transceiver Interrupt Flag Register

This block holds the interrupt and diagnostic flags of a bus transceiver. Single-cycle event strobes from the analog monitors, the bus receiver and the wake logic set sticky flags. Software reads one 32-bit word and clears flags by writing ones to them. Several read-only bits are computed from the flags: a wake-request summary, a bus-error summary, a voltage/temperature summary, a masked summary of serial-port errors, a mirror of a companion core's interrupt, and a global error bit.

The operating mode comes in as a 2-bit level from an external mode controller. The block registers the mode and watches it for transitions. Some transitions clear flags on their own: leaving standby for sleep or normal clears the power-on flag, and entering normal or sleep clears both wake flags. A bus-normal status bit follows the bus edge strobe while the part is in normal mode. The active-low interrupt pin goes low while any enabled flag other than the bus-normal status bit is set.

Events and software writes take effect at the next clock edge. The read word and the interrupt pin are combinational views of the registered flags and the current inputs. Every pin is a plain level or strobe, so the block has no valid/ready handshake and no back-pressure.

Top module: `xcvr_irq_flags`

## Requirements
- R1: After reset the read word is 32'h0000_0001: only the power-on flag (bit 0) is set.
- R2: The clearable flags are power-on bit 0, supply undervoltage bit 1, thermal bit 2, ECC bit 3, bus-wake bit 4, local-wake bit 5, wake-error bit 6, bus-silent bit 7 and stuck-dominant bit 8. Each flag except power-on is set by its event strobe on the next edge and then holds. When an event and a clearing write arrive in the same cycle, the event wins.
- R3: A write with a 1 in bit i clears clearable flag i. A 0 in a bit has no effect. Bits 9–15, 17–23, 29 and 30 always read 0. Writes to those bits and to the read-only bits change nothing.
- R4: The power-on flag clears when the registered mode is standby (2'b01) and the mode input is sleep (2'b00) or normal (2'b10). Any other mode change leaves it set.
- R5: A bus-wake event is ignored while the local-wake flag is set. A local-wake event is ignored while the bus-wake flag is set.
- R6: Both wake flags clear when the mode input differs from the registered mode and is normal or sleep.
- R7: Bit 24 is bus-wake OR local-wake OR wake-error. Bit 25 is bus-silent OR stuck-dominant. Bit 26 is supply undervoltage OR the filtered-supply undervoltage input OR thermal OR ECC.
- R8: Bit 27 is the OR, over the 15 serial-status bits, of each status bit ANDed with its enable bit.
- R9: Bit 28 mirrors the companion core interrupt input. Bit 31 is the OR of bit 27, bit 28, both undervoltage conditions, thermal, ECC, wake-error, bus-silent and stuck-dominant.
- R10: Bit 16 (bus normal) sets on a bus edge strobe while the mode input is normal. It clears whenever the mode input is not normal, and on a bus-silent or stuck-dominant event in normal mode. A fault in the same cycle as an edge wins.
- R11: irq_n is 0 exactly when the read word ANDed with irq_en is non-zero, with bit 16 excluded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_in | input | 2 | Mode level: 00 sleep, 01 standby, 10 normal, 11 unused |
| reg_wr_en | input | 1 | Write strobe for the flag word |
| reg_wr_data | input | 32 | Write data; ones clear flags |
| reg_rd_data | output | 32 | Flag word |
| ev_uv_sup | input | 1 | Supply undervoltage event |
| uv_fltr_low | input | 1 | Filtered-supply undervoltage level |
| ev_thermal | input | 1 | Thermal shutdown event |
| ev_ecc_fatal | input | 1 | Uncorrectable ECC event |
| ev_bus_wake | input | 1 | Bus wake-up event |
| ev_local_wake | input | 1 | Local wake pin event |
| ev_wake_err | input | 1 | Wake error event |
| ev_bus_silent | input | 1 | Bus silent fault event |
| ev_bus_stuck_dom | input | 1 | Bus stuck-dominant fault event |
| bus_dom_rec_edge | input | 1 | Dominant-to-recessive bus transition strobe |
| spi_stat | input | 15 | Serial-port error status bits |
| spi_stat_en | input | 15 | Per-bit enables for spi_stat |
| core_irq_any | input | 1 | Companion core interrupt summary |
| irq_en | input | 32 | Interrupt enables per bit of the flag word |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
On every cycle, the assertions check the wake lockout, the wake clear on mode entry, the allowed causes for the power-on flag falling, event priority on the thermal flag, reserved bits reading zero, bus normal appearing only after normal mode, and the interrupt pin never asserting without an enabled set bit. The bench's scenarios are needed for the rest: power-on flag behaviour across chains of mode changes with resets in between, which write patterns leave flags untouched, the masked serial summary, and how the bus-normal bit orders an edge against a fault. A behavioural model compares the whole word and the pin on every clock.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_STBY  = 2'b01,
    MODE_NORM  = 2'b10,
    MODE_RSVD  = 2'b11
  } irqf_mode_e;

  localparam int WORD_W   = 32;
  localparam int SPI_W    = 15;
  localparam int N_CLR    = 9;

  localparam int F_PWR    = 0;
  localparam int F_UV     = 1;
  localparam int F_TSD    = 2;
  localparam int F_ECC    = 3;
  localparam int F_BWAKE  = 4;
  localparam int F_LWAKE  = 5;
  localparam int F_WERR   = 6;
  localparam int F_SIL    = 7;
  localparam int F_DOM    = 8;

  localparam int B_BUSNORM = 16;
  localparam int B_WREQ    = 24;
  localparam int B_BUSERR  = 25;
  localparam int B_VTWD    = 26;
  localparam int B_SPIERR  = 27;
  localparam int B_CORE    = 28;
  localparam int B_GLOBAL  = 31;

  localparam logic [N_CLR-1:0] CLR_RST = 9'h001;
  localparam logic [WORD_W-1:0] RSVD_MASK = 32'h60FE_FE00;
endpackage

// File: rtl/irqf_mode_track.sv
module irqf_mode_track
  import irqf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  output logic [1:0] mode_q,
  output logic       pwr_clr,
  output logic       wake_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STBY;
    else        mode_q <= mode_in;
  end

  logic into_run_or_sleep;
  assign into_run_or_sleep = (mode_in == MODE_NORM) || (mode_in == MODE_SLEEP);
  assign pwr_clr  = (mode_q == MODE_STBY) && into_run_or_sleep;
  assign wake_clr = (mode_in != mode_q) && into_run_or_sleep;
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic blk,
  input  logic sw_clr,
  input  logic auto_clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= RST_VAL;
    else if (ev && !blk)       q <= 1'b1;
    else if (sw_clr || auto_clr) q <= 1'b0;
  end
endmodule

// File: rtl/irqf_bus_status.sv
module irqf_bus_status (
  input  logic clk,
  input  logic rst_n,
  input  logic in_norm,
  input  logic edge_seen,
  input  logic fault,
  output logic bus_normal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bus_normal <= 1'b0;
    else if (!in_norm || fault) bus_normal <= 1'b0;
    else if (edge_seen)        bus_normal <= 1'b1;
  end
endmodule

// File: rtl/irqf_summary.sv
module irqf_summary
  import irqf_pkg::*;
(
  input  logic [N_CLR-1:0]  flags,
  input  logic              bus_normal,
  input  logic              uv_fltr_low,
  input  logic [SPI_W-1:0]  spi_stat,
  input  logic [SPI_W-1:0]  spi_stat_en,
  input  logic              core_irq_any,
  input  logic [WORD_W-1:0] irq_en,
  output logic [WORD_W-1:0] word,
  output logic              irq_n
);
  logic wreq, buserr, vtwd, spierr, glob;
  logic [WORD_W-1:0] irq_mask;

  always_comb begin
    wreq   = flags[F_BWAKE] | flags[F_LWAKE] | flags[F_WERR];
    buserr = flags[F_SIL] | flags[F_DOM];
    vtwd   = flags[F_UV] | uv_fltr_low | flags[F_TSD] | flags[F_ECC];
    spierr = |(spi_stat & spi_stat_en);
    glob   = vtwd | flags[F_WERR] | buserr | spierr | core_irq_any;

    word = '0;
    word[N_CLR-1:0] = flags;
    word[B_BUSNORM] = bus_normal;
    word[B_WREQ]    = wreq;
    word[B_BUSERR]  = buserr;
    word[B_VTWD]    = vtwd;
    word[B_SPIERR]  = spierr;
    word[B_CORE]    = core_irq_any;
    word[B_GLOBAL]  = glob;

    irq_mask = irq_en;
    irq_mask[B_BUSNORM] = 1'b0;
    irq_n = ~|(word & irq_mask);
  end
endmodule

// File: rtl/xcvr_irq_flags.sv
module xcvr_irq_flags
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_in,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wr_data,
  output logic [WORD_W-1:0] reg_rd_data,
  input  logic              ev_uv_sup,
  input  logic              uv_fltr_low,
  input  logic              ev_thermal,
  input  logic              ev_ecc_fatal,
  input  logic              ev_bus_wake,
  input  logic              ev_local_wake,
  input  logic              ev_wake_err,
  input  logic              ev_bus_silent,
  input  logic              ev_bus_stuck_dom,
  input  logic              bus_dom_rec_edge,
  input  logic [SPI_W-1:0]  spi_stat,
  input  logic [SPI_W-1:0]  spi_stat_en,
  input  logic              core_irq_any,
  input  logic [WORD_W-1:0] irq_en,
  output logic              irq_n
);
  logic [1:0]       mode_q;
  logic             pwr_clr, wake_clr, bus_normal;
  logic [N_CLR-1:0] flags, ev_vec, blk_vec, auto_vec, sw_vec;

  irqf_mode_track u_mode (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in),
    .mode_q(mode_q), .pwr_clr(pwr_clr), .wake_clr(wake_clr)
  );

  always_comb begin
    ev_vec = {ev_bus_stuck_dom, ev_bus_silent, ev_wake_err, ev_local_wake,
              ev_bus_wake, ev_ecc_fatal, ev_thermal, ev_uv_sup, 1'b0};
    blk_vec = '0;
    blk_vec[F_BWAKE] = flags[F_LWAKE];
    blk_vec[F_LWAKE] = flags[F_BWAKE];
    auto_vec = '0;
    auto_vec[F_PWR]   = pwr_clr;
    auto_vec[F_BWAKE] = wake_clr;
    auto_vec[F_LWAKE] = wake_clr;
    sw_vec = reg_wr_en ? reg_wr_data[N_CLR-1:0] : '0;
  end

  for (genvar i = 0; i < N_CLR; i++) begin : g_flag
    irqf_flag_cell #(.RST_VAL(CLR_RST[i])) u_cell (
      .clk(clk), .rst_n(rst_n), .ev(ev_vec[i]), .blk(blk_vec[i]),
      .sw_clr(sw_vec[i]), .auto_clr(auto_vec[i]), .q(flags[i])
    );
  end

  irqf_bus_status u_bus (
    .clk(clk), .rst_n(rst_n), .in_norm(mode_in == MODE_NORM),
    .edge_seen(bus_dom_rec_edge), .fault(ev_bus_silent | ev_bus_stuck_dom),
    .bus_normal(bus_normal)
  );

  irqf_summary u_sum (
    .flags(flags), .bus_normal(bus_normal), .uv_fltr_low(uv_fltr_low),
    .spi_stat(spi_stat), .spi_stat_en(spi_stat_en), .core_irq_any(core_irq_any),
    .irq_en(irq_en), .word(reg_rd_data), .irq_n(irq_n)
  );
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
  import irqf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_in,
  input logic [1:0]        mode_q,
  input logic              reg_wr_en,
  input logic [WORD_W-1:0] reg_wr_data,
  input logic [WORD_W-1:0] reg_rd_data,
  input logic              ev_thermal,
  input logic              ev_bus_wake,
  input logic              ev_local_wake,
  input logic [WORD_W-1:0] irq_en,
  input logic              irq_n
);
  p_evt_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_thermal |=> reg_rd_data[F_TSD]);

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data & RSVD_MASK) == '0);

  p_pwr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rd_data[F_PWR]) |->
      ($past(reg_wr_en && reg_wr_data[F_PWR]) ||
       ($past(mode_q) == MODE_STBY &&
        ($past(mode_in) == MODE_SLEEP || $past(mode_in) == MODE_NORM))));

  p_lock_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[F_LWAKE] && !reg_rd_data[F_BWAKE]) |=> !reg_rd_data[F_BWAKE]);

  p_lock_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[F_BWAKE] && !reg_rd_data[F_LWAKE]) |=> !reg_rd_data[F_LWAKE]);

  p_wake_modeclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in != mode_q && (mode_in == MODE_NORM || mode_in == MODE_SLEEP) &&
     !ev_bus_wake && !ev_local_wake)
      |=> (!reg_rd_data[F_BWAKE] && !reg_rd_data[F_LWAKE]));

  p_wreq_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[B_WREQ] == (reg_rd_data[F_BWAKE] | reg_rd_data[F_LWAKE] | reg_rd_data[F_WERR]));

  p_busnorm_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rd_data[B_BUSNORM]) |-> $past(mode_in) == MODE_NORM);

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (reg_rd_data & irq_en) != '0);
endmodule

bind xcvr_irq_flags irqf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .mode_q(mode_q),
  .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
  .ev_thermal(ev_thermal), .ev_bus_wake(ev_bus_wake), .ev_local_wake(ev_local_wake),
  .irq_en(irq_en), .irq_n(irq_n)
);

// File: tb/xcvr_irq_flags_tb.sv
module xcvr_irq_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_in = 2'b01;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic ev_uv_sup = 0, uv_fltr_low = 0, ev_thermal = 0, ev_ecc_fatal = 0;
  logic ev_bus_wake = 0, ev_local_wake = 0, ev_wake_err = 0;
  logic ev_bus_silent = 0, ev_bus_stuck_dom = 0, bus_dom_rec_edge = 0;
  logic [14:0] spi_stat = '0, spi_stat_en = '0;
  logic        core_irq_any = 0;
  logic [31:0] irq_en = '1;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  xcvr_irq_flags u_dut (.*);

  // behavioural reference model
  logic m_pwr, m_uv, m_tsd, m_ecc, m_bw, m_lw, m_we, m_sil, m_dom, m_bn;
  logic [1:0] m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 1; m_uv = 0; m_tsd = 0; m_ecc = 0; m_bw = 0; m_lw = 0;
      m_we = 0; m_sil = 0; m_dom = 0; m_bn = 0; m_mode = 2'b01;
    end else begin
      logic [31:0] wc;
      logic old_bw, old_lw, pclr, wclr, into;
      wc = reg_wr_en ? reg_wr_data : 32'h0;
      into = (mode_in == 2'b00) || (mode_in == 2'b10);
      pclr = (m_mode == 2'b01) && into;
      wclr = (mode_in != m_mode) && into;
      old_bw = m_bw; old_lw = m_lw;
      if (wc[0] || pclr) m_pwr = 0;
      m_uv  = ev_uv_sup        ? 1 : (wc[1] ? 0 : m_uv);
      m_tsd = ev_thermal       ? 1 : (wc[2] ? 0 : m_tsd);
      m_ecc = ev_ecc_fatal     ? 1 : (wc[3] ? 0 : m_ecc);
      m_bw  = (ev_bus_wake && !old_lw)   ? 1 : ((wc[4] || wclr) ? 0 : m_bw);
      m_lw  = (ev_local_wake && !old_bw) ? 1 : ((wc[5] || wclr) ? 0 : m_lw);
      m_we  = ev_wake_err      ? 1 : (wc[6] ? 0 : m_we);
      m_sil = ev_bus_silent    ? 1 : (wc[7] ? 0 : m_sil);
      m_dom = ev_bus_stuck_dom ? 1 : (wc[8] ? 0 : m_dom);
      if (mode_in != 2'b10 || ev_bus_silent || ev_bus_stuck_dom) m_bn = 0;
      else if (bus_dom_rec_edge) m_bn = 1;
      m_mode = mode_in;
    end
  end

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    logic spi;
    spi = |(spi_stat & spi_stat_en);
    w = '0;
    w[0] = m_pwr; w[1] = m_uv; w[2] = m_tsd; w[3] = m_ecc; w[4] = m_bw;
    w[5] = m_lw; w[6] = m_we; w[7] = m_sil; w[8] = m_dom; w[16] = m_bn;
    w[24] = m_bw | m_lw | m_we;
    w[25] = m_sil | m_dom;
    w[26] = m_uv | uv_fltr_low | m_tsd | m_ecc;
    w[27] = spi;
    w[28] = core_irq_any;
    w[31] = w[26] | m_we | w[25] | spi | core_irq_any;
    return w;
  endfunction

  function automatic logic exp_irq_n();
    logic [31:0] en;
    en = irq_en;
    en[16] = 1'b0;
    return ~|(exp_word() & en);
  endfunction

  task automatic compare();
    checks++;
    if (reg_rd_data !== exp_word() || irq_n !== exp_irq_n()) begin
      errors++;
      $display("FAIL %s: rd=%h irq_n=%b expected rd=%h irq_n=%b",
               cur_req, reg_rd_data, irq_n, exp_word(), exp_irq_n());
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    mode_in = 2'b01;
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick();
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1; reg_wr_data = d;
    tick();
    reg_wr_en = 0; reg_wr_data = '0;
  endtask

  task automatic go(input logic [1:0] m);
    mode_in = m;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", reg_rd_data, 32'h0000_0001);
    chk("R11", {31'b0, irq_n}, 32'h0);

    // R4 chains of mode changes
    cur_req = "R4";
    go(2'b11); go(2'b10);
    chk("R4", {31'b0, reg_rd_data[0]}, 32'h1);
    go(2'b01); go(2'b10);
    chk("R4", {31'b0, reg_rd_data[0]}, 32'h0);
    do_reset();
    go(2'b00);
    chk("R4", {31'b0, reg_rd_data[0]}, 32'h0);
    do_reset();
    cur_req = "R3";
    wr(32'h0000_0000);
    chk("R3", reg_rd_data, 32'h0000_0001);
    wr(32'h0000_0001);
    chk("R3", reg_rd_data, 32'h0000_0000);

    // R2 events, holding, event wins
    cur_req = "R2";
    ev_thermal = 1; tick(); ev_thermal = 0;
    chk("R2", {31'b0, reg_rd_data[2]}, 32'h1);
    tick();
    chk("R7", {31'b0, reg_rd_data[26]}, 32'h1);
    chk("R9", {31'b0, reg_rd_data[31]}, 32'h1);
    ev_thermal = 1; reg_wr_en = 1; reg_wr_data = 32'h4; tick();
    ev_thermal = 0; reg_wr_en = 0; reg_wr_data = 0;
    chk("R2", {31'b0, reg_rd_data[2]}, 32'h1);
    cur_req = "R3";
    wr(32'hFFFF_FE00);
    chk("R3", reg_rd_data, 32'h8400_0004);
    wr(32'h0000_0004);
    chk("R3", reg_rd_data, 32'h0);
    cur_req = "R2";
    ev_uv_sup = 1; ev_ecc_fatal = 1; ev_wake_err = 1; ev_bus_stuck_dom = 1; tick();
    ev_uv_sup = 0; ev_ecc_fatal = 0; ev_wake_err = 0; ev_bus_stuck_dom = 0;
    chk("R2", reg_rd_data, 32'h8700_014A);
    wr(32'hFFFF_FFFF);
    cur_req = "R7";
    uv_fltr_low = 1; tick();
    chk("R7", reg_rd_data, 32'h8400_0000);
    uv_fltr_low = 0; tick();

    // R5 lockout
    cur_req = "R5";
    ev_bus_wake = 1; tick(); ev_bus_wake = 0;
    ev_local_wake = 1; tick(); ev_local_wake = 0;
    chk("R5", reg_rd_data, 32'h0100_0010);
    wr(32'h0000_0010);
    ev_local_wake = 1; tick(); ev_local_wake = 0;
    ev_bus_wake = 1; tick(); ev_bus_wake = 0;
    chk("R5", reg_rd_data, 32'h0100_0020);

    // R6 wake flags cleared on mode entry
    cur_req = "R6";
    go(2'b00);
    chk("R6", reg_rd_data, 32'h0);
    ev_bus_wake = 1; tick(); ev_bus_wake = 0;
    tick();
    chk("R6", {31'b0, reg_rd_data[4]}, 32'h1);
    go(2'b10);
    chk("R6", reg_rd_data, 32'h0);

    // R10 bus normal
    cur_req = "R10";
    irq_en = 32'h0001_0000;
    bus_dom_rec_edge = 1; tick(); bus_dom_rec_edge = 0;
    chk("R10", reg_rd_data, 32'h0001_0000);
    chk("R11", {31'b0, irq_n}, 32'h1);
    ev_bus_silent = 1; bus_dom_rec_edge = 1; tick();
    ev_bus_silent = 0; bus_dom_rec_edge = 0;
    chk("R10", reg_rd_data, 32'h8200_0080);
    bus_dom_rec_edge = 1; tick(); bus_dom_rec_edge = 0;
    chk("R10", {31'b0, reg_rd_data[16]}, 32'h1);
    go(2'b01);
    chk("R10", {31'b0, reg_rd_data[16]}, 32'h0);
    bus_dom_rec_edge = 1; tick(); bus_dom_rec_edge = 0;
    chk("R10", {31'b0, reg_rd_data[16]}, 32'h0);
    wr(32'hFFFF_FFFF);

    // R8 masked serial summary
    cur_req = "R8";
    irq_en = '1;
    spi_stat = 15'h0004; spi_stat_en = 15'h7FFB; tick();
    chk("R8", reg_rd_data, 32'h0);
    spi_stat_en = 15'h0004; tick();
    chk("R8", reg_rd_data, 32'h8800_0000);
    spi_stat = '0; spi_stat_en = '0;

    // R9 core mirror and global
    cur_req = "R9";
    core_irq_any = 1; tick();
    chk("R9", reg_rd_data, 32'h9000_0000);
    cur_req = "R11";
    irq_en = 32'h0;
    tick();
    chk("R11", {31'b0, irq_n}, 32'h1);
    irq_en = 32'h1000_0000; tick();
    chk("R11", {31'b0, irq_n}, 32'h0);
    core_irq_any = 0; tick();
    chk("R9", reg_rd_data, 32'h0);
    chk("R11", {31'b0, irq_n}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule